// File: doc/BRIEF.md
# Serial Port Register Block

This block is the word-addressed register front end of a simple serial port. A bus master reads and writes 32-bit words. Received bytes go into a 16-entry queue. The master inspects them through two status words: one returns the oldest byte and leaves the queue alone, the other returns the oldest byte and removes it. A write to the data-out word sends its low byte toward the transmitter. The byte is offered with a valid strobe that stays high until the transmit side accepts it.

A level interrupt is built from three registers. A raw register collects events, a mask register selects which events count, and an acknowledge register clears raw bits. The receive side sees a ready flag and a free-space count, and both stay zero until software sets the receiver enable bit. Bit serialization, baud timing and DMA belong to neighbouring blocks.

Top module: `serport_regs`

## Requirements
- R1: Byte offsets: 0x00 tx control, 0x04 tx DMA enable, 0x08 rx control, 0x1C data out, 0x20 status-pop, 0x24 status-peek, 0x2C interrupt mask, 0x30 acknowledge, 0x34 raw interrupt, 0x38 masked interrupt. Offsets below 0x3C with no special role are plain read/write words. The status, raw and masked words ignore writes. Any address at or above 0x3C reads as zero and ignores writes. Read data appears on `bus_rdata`, with `bus_rvalid` high, in the cycle after the read is presented.
- R2: The receive queue holds 16 bytes and returns them in arrival order. A byte that arrives while 16 are held is discarded, and this holds even when a pop happens in the same cycle.
- R3: Both status words return the oldest queued byte in bits [7:0]. Bit 16 is 1 when the queue is non-empty. Bits 24 and 22 are always 1. All other bits are 0.
- R4: Reading status-peek never changes the queue. Reading status-pop removes the oldest byte when the queue is non-empty and does nothing when it is empty. A byte arriving in the same cycle as a pop is still stored, and the count stays exact.
- R5: Raw interrupt bit 3 takes the queue's non-empty state after every bus write and after every stored byte. A pop alone does not update it.
- R6: A data-out write raises `tx_valid` with the written low byte on `tx_data` in the next cycle. `tx_valid` holds until a cycle with `tx_accept` high. The write also sets raw bits 0 and 1, sets a pending-transmit flag, and the full word reads back from 0x1C.
- R7: An acknowledge write clears the raw bits set in the written value. If the pending-transmit flag is set, bit 0 is first removed from the value and the flag is cleared. The adjusted value is what reads back from 0x30.
- R8: The masked word reads raw AND mask, and `irq` is high exactly when that value is non-zero.
- R9: Bytes are stored only while rx control bit 3 is 1. While it is 0, `rx_ready` and `rx_space` are 0. While it is 1, `rx_space` is 16 minus the occupancy and `rx_ready` is high when the queue is not full.
- R10: After reset, rx control reads 0x00010000. Every other register, the queue, the pending flag, `irq` and `tx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; ignored when bus_wr is high |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High for one cycle when bus_rdata carries a read result |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receiver enabled and queue not full |
| rx_space | output | $clog2(FIFO_DEPTH+1) (5) | Free queue entries, 0 while disabled |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_accept | input | 1 | Transmit side takes the offered byte |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check on every cycle that the queue count never exceeds its depth, and that the count does not move when the receiver is disabled, when the queue is full, or when the peek word is read. They also check that `irq` equals the OR of raw AND mask, that status reads carry the constant transmitter bits, that data-out writes raise raw bits 0 and 1, and that out-of-range reads return zero. Some properties need a planned sequence and only the bench scenarios show them. These are arrival order across a full queue, the stale raw bit 3 after a pop until the next write, the spared bit 0 on the first acknowledge after a transmit, and the exact count when a byte and a pop meet in the same cycle.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int NWORDS = 15;
  localparam logic [3:0] IDX_RXCTL  = 4'd2;
  localparam logic [3:0] IDX_DOUT   = 4'd7;
  localparam logic [3:0] IDX_STPOP  = 4'd8;
  localparam logic [3:0] IDX_STPEEK = 4'd9;
  localparam logic [3:0] IDX_MASK   = 4'd11;
  localparam logic [3:0] IDX_ACK    = 4'd12;
  localparam logic [3:0] IDX_RAW    = 4'd13;
  localparam logic [3:0] IDX_MSKD   = 4'd14;
  localparam int BIT_AVAIL = 16;
  localparam int BIT_TIDLE = 22;
  localparam int BIT_TRDY  = 24;
  localparam int BIT_RXEN  = 3;
  localparam int IRQ_RXQ   = 3;
  localparam logic [31:0] RXCTL_RESET = 32'h0001_0000;
endpackage

// File: rtl/serport_rxq.sv
module serport_rxq #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push_i,
  input  logic [DW-1:0]                  pdata_i,
  input  logic                           pop_i,
  output logic                           accept_o,
  output logic [DW-1:0]                  head_o,
  output logic [$clog2(DEPTH+1)-1:0]     count_o,
  output logic [$clog2(DEPTH+1)-1:0]     count_nx_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q, count_d;
  logic          push_ok, pop_ok;

  assign push_ok = push_i && (count_q < FULL);
  assign pop_ok  = pop_i && (count_q != '0);

  always_comb begin
    count_d = count_q;
    if (push_ok && !pop_ok) count_d = count_q + 1'b1;
    else if (!push_ok && pop_ok) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= pdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      count_q <= count_d;
    end
  end

  assign accept_o   = push_ok;
  assign head_o     = mem[rptr_q];
  assign count_o    = count_q;
  assign count_nx_o = count_d;

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    count_q <= FULL);
  assert_full_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && count_q == FULL) |=> (count_q == FULL && $stable(wptr_q)));
  assert_pop_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && count_q == '0) |=> (count_q == '0 && $stable(rptr_q)));
endmodule

// File: rtl/serport_irq.sv
module serport_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tx_wr_i,
  input  logic         ack_wr_i,
  input  logic         any_wr_i,
  input  logic         rx_acc_i,
  input  logic         nonempty_nx_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] mask_d_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] ack_val_o,
  output logic         irq_o
);
  import serport_pkg::*;

  logic [W-1:0] raw_q, raw_d;
  logic         pend_q, irq_q;

  assign ack_val_o = pend_q ? (wdata_i & ~W'(1)) : wdata_i;

  always_comb begin
    raw_d = raw_q;
    if (tx_wr_i)  raw_d[1:0] = 2'b11;
    if (ack_wr_i) raw_d = raw_d & ~ack_val_o;
    if (any_wr_i || rx_acc_i) raw_d[IRQ_RXQ] = nonempty_nx_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      raw_q <= raw_d;
      irq_q <= |(raw_d & mask_d_i);
      if (tx_wr_i) pend_q <= 1'b1;
      else if (ack_wr_i) pend_q <= 1'b0;
    end
  end

  assign raw_o = raw_q;
  assign irq_o = irq_q;

  assert_tx_sets_R6: assert property (@(posedge clk) disable iff (rst)
    tx_wr_i |=> (raw_o[1:0] == 2'b11));
  assert_ack_spare_R7: assert property (@(posedge clk) disable iff (rst)
    (ack_wr_i && pend_q) |=> (raw_o[0] == $past(raw_o[0]) && !pend_q));
  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (ack_wr_i && !pend_q) |=> ((raw_o & $past(wdata_i) & ~W'(8)) == '0));
endmodule

// File: rtl/serport_regs.sv
module serport_regs #(
  parameter int ADDR_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int DW         = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            bus_wr,
  input  logic                            bus_rd,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [31:0]                     bus_wdata,
  output logic [31:0]                     bus_rdata,
  output logic                            bus_rvalid,
  input  logic                            rx_valid,
  input  logic [DW-1:0]                   rx_data,
  output logic                            rx_ready,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] rx_space,
  output logic                            tx_valid,
  output logic [DW-1:0]                   tx_data,
  input  logic                            tx_accept,
  output logic                            irq
);
  import serport_pkg::*;

  localparam int CW = $clog2(FIFO_DEPTH+1);
  localparam logic [CW-1:0] FULL = CW'(FIFO_DEPTH);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NWORDS*4);

  logic [3:0]  idx;
  logic        in_range, wr_fire, rd_fire, pop, push_acc, rx_en;
  logic [NWORDS-1:0][31:0] word_v;
  logic [31:0] mask_q, mask_d, raw, ack_val, status, rd_word;
  logic [DW-1:0] head;
  logic [CW-1:0] count, count_nx;
  logic [31:0] rdata_q;
  logic        rvalid_q, txv_q;
  logic [DW-1:0] txd_q;

  assign idx      = bus_addr[5:2];
  assign in_range = bus_addr < SPAN;
  assign wr_fire  = bus_wr && in_range;
  assign rd_fire  = bus_rd && !bus_wr;
  assign pop      = rd_fire && in_range && (idx == IDX_STPOP);
  assign rx_en    = word_v[IDX_RXCTL][BIT_RXEN];

  serport_rxq #(.DEPTH(FIFO_DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst(rst),
    .push_i(rx_valid && rx_en), .pdata_i(rx_data), .pop_i(pop),
    .accept_o(push_acc), .head_o(head), .count_o(count), .count_nx_o(count_nx)
  );

  // plain and special-write words; read-only slots are tied off
  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
    localparam logic [3:0] GI = 4'(gi);
    if (GI == IDX_STPOP || GI == IDX_STPEEK || GI == IDX_RAW || GI == IDX_MSKD) begin : g_ro
      assign word_v[gi] = '0;
    end else begin : g_rw
      logic [31:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= (GI == IDX_RXCTL) ? RXCTL_RESET : '0;
        else if (wr_fire && idx == GI) q <= (GI == IDX_ACK) ? ack_val : bus_wdata;
      end
      assign word_v[gi] = q;
    end
  end

  assign mask_q = word_v[IDX_MASK];
  assign mask_d = (wr_fire && idx == IDX_MASK) ? bus_wdata : mask_q;

  serport_irq #(.W(32)) u_irq (
    .clk(clk), .rst(rst),
    .tx_wr_i(wr_fire && idx == IDX_DOUT),
    .ack_wr_i(wr_fire && idx == IDX_ACK),
    .any_wr_i(wr_fire),
    .rx_acc_i(push_acc),
    .nonempty_nx_i(count_nx != '0),
    .wdata_i(bus_wdata), .mask_d_i(mask_d),
    .raw_o(raw), .ack_val_o(ack_val), .irq_o(irq)
  );

  always_comb begin
    status = 32'(head);
    status[BIT_AVAIL] = (count != '0);
    status[BIT_TIDLE] = 1'b1;
    status[BIT_TRDY]  = 1'b1;
    unique case (idx)
      IDX_STPOP, IDX_STPEEK: rd_word = status;
      IDX_RAW:               rd_word = raw;
      IDX_MSKD:              rd_word = raw & mask_q;
      default:               rd_word = word_v[idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      txv_q    <= 1'b0;
      txd_q    <= '0;
    end else begin
      rvalid_q <= rd_fire;
      if (rd_fire) rdata_q <= in_range ? rd_word : '0;
      if (wr_fire && idx == IDX_DOUT) begin
        txv_q <= 1'b1;
        txd_q <= bus_wdata[DW-1:0];
      end else if (tx_accept) begin
        txv_q <= 1'b0;
      end
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign tx_valid   = txv_q;
  assign tx_data    = txd_q;
  assign rx_ready   = rx_en && (count < FULL);
  assign rx_space   = rx_en ? (FULL - count) : '0;

  assert_oor_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && !in_range) |=> (bus_rdata == '0 && bus_rvalid));
  assert_status_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && in_range && (idx == IDX_STPOP || idx == IDX_STPEEK)) |=>
      (bus_rdata[BIT_TRDY] && bus_rdata[BIT_TIDLE] && bus_rdata[BIT_AVAIL] == $past(count != '0)));
  assert_peek_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && in_range && idx == IDX_STPEEK && !push_acc) |=> (count == $past(count)));
  assert_tx_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && idx == IDX_DOUT) |=> (tx_valid && tx_data == $past(bus_wdata[DW-1:0])));
  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    irq == |(raw & mask_q));
  assert_rx_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_en && !pop) |=> (count == $past(count)));
endmodule

// File: tb/tb_serport_regs.sv
module tb_serport_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic [4:0]  rx_space;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_accept = 1'b0;
  logic        irq;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  logic [31:0] msk_q[$];
  string       tag_q[$];

  localparam logic [31:0] ST  = 32'h0140_0000;
  localparam logic [31:0] STA = 32'h0141_0000;

  always #10 clk = ~clk;

  serport_regs dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .rx_space(rx_space),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_accept(tx_accept), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as read results appear
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R1 unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e, m;
        string t;
        e = exp_q.pop_front(); m = msk_q.pop_front(); t = tag_q.pop_front();
        chk(t, bus_rdata & m, e & m);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input logic [31:0] m, input string t);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); msk_q.push_back(m); tag_q.push_back(t);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rxb(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 irq", {31'd0, irq}, 32'd0);
    chk("R10 tx_valid", {31'd0, tx_valid}, 32'd0);
    chk("R9 rx_space disabled", {27'd0, rx_space}, 32'd0);
    chk("R9 rx_ready disabled", {31'd0, rx_ready}, 32'd0);
    rd(8'h08, 32'h0001_0000, '1, "R10 rxctl");
    rd(8'h2C, 0, '1, "R10 mask");
    rd(8'h34, 0, '1, "R10 raw");
    rd(8'h24, ST, 32'hFFFF_FF00, "R3 empty status");
    // R9 byte while disabled is ignored
    rxb(8'h55);
    rd(8'h24, ST, 32'hFFFF_FF00, "R9 disabled drop");
    rd(8'h34, 0, '1, "R9 raw untouched");
    // enable
    wr(8'h08, 32'h0001_0008);
    chk("R9 rx_space enabled", {27'd0, rx_space}, 32'd16);
    chk("R9 rx_ready enabled", {31'd0, rx_ready}, 32'd1);
    rxb(8'hA1); rxb(8'hA2);
    chk("R9 rx_space two", {27'd0, rx_space}, 32'd14);
    rd(8'h24, STA | 32'hA1, '1, "R4 peek one");
    rd(8'h24, STA | 32'hA1, '1, "R4 peek again");
    rd(8'h20, STA | 32'hA1, '1, "R4 pop first");
    rd(8'h24, STA | 32'hA2, '1, "R4 peek after pop");
    rd(8'h34, 32'h8, '1, "R5 raw bit3 on byte");
    chk("R8 irq masked off", {31'd0, irq}, 32'd0);
    wr(8'h2C, 32'h8);
    chk("R8 irq on", {31'd0, irq}, 32'd1);
    rd(8'h38, 32'h8, '1, "R8 masked word");
    rd(8'h20, STA | 32'hA2, '1, "R4 pop last");
    rd(8'h20, ST, 32'hFFFF_FF00, "R4 pop empty");
    rd(8'h34, 32'h8, '1, "R5 stale bit3 after pop");
    chk("R5 irq still set", {31'd0, irq}, 32'd1);
    wr(8'h04, 32'h5);
    rd(8'h34, 0, '1, "R5 bit3 cleared on write");
    chk("R8 irq off", {31'd0, irq}, 32'd0);
    rd(8'h04, 32'h5, '1, "R1 plain word");
    // R2 fill beyond depth
    for (int i = 0; i < 18; i++) rxb(8'h10 + 8'(i));
    chk("R2 space full", {27'd0, rx_space}, 32'd0);
    chk("R9 ready full", {31'd0, rx_ready}, 32'd0);
    for (int i = 0; i < 16; i++) rd(8'h20, STA | (32'h10 + 32'(i)), '1, "R2 order");
    rd(8'h24, ST, 32'hFFFF_FF00, "R2 empty after drain");
    // R6 transmit
    wr(8'h1C, 32'h1234_56C3);
    chk("R6 tx_valid", {31'd0, tx_valid}, 32'd1);
    chk("R6 tx_data", {24'd0, tx_data}, 32'hC3);
    @(negedge clk);
    chk("R6 tx_valid held", {31'd0, tx_valid}, 32'd1);
    tx_accept = 1'b1; @(negedge clk); tx_accept = 1'b0;
    chk("R6 tx_valid dropped", {31'd0, tx_valid}, 32'd0);
    rd(8'h34, 32'h3, '1, "R6 raw bits");
    rd(8'h1C, 32'h1234_56C3, '1, "R6 readback");
    // R7 acknowledge
    wr(8'h30, 32'h3);
    rd(8'h34, 32'h1, '1, "R7 bit0 spared");
    rd(8'h30, 32'h2, '1, "R7 adjusted stored");
    wr(8'h30, 32'h1);
    rd(8'h34, 32'h0, '1, "R7 second ack clears");
    rd(8'h30, 32'h1, '1, "R7 plain stored");
    wr(8'h2C, 32'h3);
    wr(8'h1C, 32'h0000_0041);
    chk("R8 irq from tx", {31'd0, irq}, 32'd1);
    tx_accept = 1'b1; @(negedge clk); tx_accept = 1'b0;
    wr(8'h30, 32'h3);
    chk("R8 irq bit0 remains", {31'd0, irq}, 32'd1);
    wr(8'h30, 32'h1);
    chk("R8 irq cleared", {31'd0, irq}, 32'd0);
    // R1 out of range and read-only words
    wr(8'h3C, 32'hFFFF);
    rd(8'h3C, 0, '1, "R1 oor 3C");
    rd(8'h40, 0, '1, "R1 oor 40");
    wr(8'h34, 32'hFF);
    rd(8'h34, 0, '1, "R1 raw read-only");
    // R4 push and pop in the same cycle
    rxb(8'h61); rxb(8'h62);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h77; bus_rd = 1'b1; bus_addr = 8'h20;
    exp_q.push_back(STA | 32'h61); msk_q.push_back('1); tag_q.push_back("R4 pop with push");
    @(negedge clk); rx_valid = 1'b0; bus_rd = 1'b0;
    chk("R4 count exact", {27'd0, rx_space}, 32'd14);
    rd(8'h24, STA | 32'h62, '1, "R4 head after overlap");
    rd(8'h20, STA | 32'h62, '1, "R4 pop 62");
    rd(8'h20, STA | 32'h77, '1, "R4 pop 77");
    repeat (3) @(negedge clk);
    chk("R1 all reads returned", 32'(exp_q.size()), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule